// File: doc/BRIEF.md
# Twelve-Line GPIO Block with Latched Level Interrupts

This block gives software control of twelve general-purpose pins through a small register bank on a 32-bit read/write register bus. Each pin has an output value and a drive-enable bit. Its input is passed through a two-stage synchroniser, and software reads the synchronised value. A separate 32-bit routing register is stored and presented on a port, where other logic uses it to select pin functions.

Any pin can raise a level-sensitive interrupt. Each line can be set to trigger while the pin is high or while it is low. A matching level latches the line's status bit. The status bit stays set until software writes a one to it. If the pin is still at its active level when that write happens, the bit sets again in the same cycle. A per-line enable mask gates the latched status into one combined interrupt request. The usual start-up sequence writes zero to the enable register and then writes all-ones to the status register.

Top module: `gpio_latch_irq`

## Requirements
- R1: After reset every register holds zero: all reads return 0, `pinOut`, `pinOe` and `muxOut` are 0 and `irq` is low.
- R2: The byte offsets are: output value 0x00, drive enable 0x04, input 0x08, status 0x0C, polarity for lines 0..7 0x10, interrupt enable 0x14, polarity for lines 8..11 0x18, routing 0x1C. The output value, drive enable and interrupt enable registers keep only bits 11:0. Every unimplemented bit reads 0.
- R3: `pinOut` carries the output value register and `pinOe` carries the drive enable register (1 means the pad drives the pin, 0 means it is high-impedance). Both take a written value on the clock edge of the write.
- R4: `pinIn` is sampled through two flip-flops, and a read at 0x08 returns the synchronised value two edges after a change on the pin. Writes to 0x08 have no effect.
- R5: The polarity bit of line n is bit 4*(n mod 8) of the register at 0x10 (n < 8) or at 0x18 (n >= 8). A 0 makes the line active high and a 1 makes it active low. All other bits of both registers read 0.
- R6: In every cycle where a line's synchronised input is at its active level, its status bit (bit n at 0x0C) is set, whether or not the line is enabled. The bit stays set after the input becomes inactive.
- R7: Writing a 1 to a status bit clears it and writing a 0 leaves it unchanged. If the line is still active, the bit stays set.
- R8: `irq` is high exactly when at least one line has both its status bit and its enable bit (bit n at 0x14) set.
- R9: The routing register at 0x1C stores all 32 written bits, reads them back and drives them on `muxOut`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 5 | Register byte offset |
| busWrite | input | 1 | Write strobe, one cycle per write |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for `busAddr`, combinational |
| pinIn | input | 12 | Asynchronous pin levels |
| pinOut | output | 12 | Output value for each pin |
| pinOe | output | 12 | Drive enable for each pin |
| muxOut | output | 32 | Routing register value |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench clears a line while its pin is still active and expects the status bit to survive. A design that lets the clear win would lose the pending interrupt. It also lets a pin fall back before any clear and expects the bit to stay latched, which catches a design that only passes the live level through. It also writes zero to a pending status bit, which a plain read/write status register would wrongly clear. The polarity cases use line 0 and line 9. They catch a wrong bit position, a wrong choice between the two polarity registers, and an inverted polarity sense. The read of the input two edges after a pin change catches a synchroniser with the wrong depth.

// File: rtl/gpio_latch_pkg.sv
package gpio_latch_pkg;
  localparam int DATA_W = 32;
  localparam int REG_AW = 5;

  localparam logic [REG_AW-1:0] OFF_OUT   = 5'h00;
  localparam logic [REG_AW-1:0] OFF_OE    = 5'h04;
  localparam logic [REG_AW-1:0] OFF_IN    = 5'h08;
  localparam logic [REG_AW-1:0] OFF_STS   = 5'h0C;
  localparam logic [REG_AW-1:0] OFF_POLLO = 5'h10;
  localparam logic [REG_AW-1:0] OFF_ENA   = 5'h14;
  localparam logic [REG_AW-1:0] OFF_POLHI = 5'h18;
  localparam logic [REG_AW-1:0] OFF_MUX   = 5'h1C;

  localparam int LINES_PER_POL = 8;
  localparam int POL_STRIDE    = 4;

  typedef struct packed {
    logic wrOut;
    logic wrOe;
    logic wrSts;
    logic wrPolLo;
    logic wrEna;
    logic wrPolHi;
    logic wrMux;
  } regStrobe_t;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_OUT, SEL_OE, SEL_IN, SEL_STS,
    SEL_POLLO, SEL_ENA, SEL_POLHI, SEL_MUX
  } rdSel_t;
endpackage

// File: rtl/gpio_ctrl.sv
module gpio_ctrl
  import gpio_latch_pkg::*;
(
  input  logic [REG_AW-1:0] busAddr,
  input  logic              busWrite,
  output regStrobe_t        strobe,
  output rdSel_t            rdSel
);
  always_comb begin
    strobe = '0;
    rdSel  = SEL_NONE;
    unique case (busAddr)
      OFF_OUT:   begin rdSel = SEL_OUT;   strobe.wrOut   = busWrite; end
      OFF_OE:    begin rdSel = SEL_OE;    strobe.wrOe    = busWrite; end
      OFF_IN:    begin rdSel = SEL_IN;    end
      OFF_STS:   begin rdSel = SEL_STS;   strobe.wrSts   = busWrite; end
      OFF_POLLO: begin rdSel = SEL_POLLO; strobe.wrPolLo = busWrite; end
      OFF_ENA:   begin rdSel = SEL_ENA;   strobe.wrEna   = busWrite; end
      OFF_POLHI: begin rdSel = SEL_POLHI; strobe.wrPolHi = busWrite; end
      OFF_MUX:   begin rdSel = SEL_MUX;   strobe.wrMux   = busWrite; end
      default:   begin rdSel = SEL_NONE;  end
    endcase
  end
endmodule

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
  parameter int WIDTH  = 12,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int k = 0; k < STAGES; k++) chain[k] <= '0;
    end else begin
      chain[0] <= asyncIn;
      for (int k = 1; k < STAGES; k++) chain[k] <= chain[k-1];
    end
  end

  assign syncOut = chain[STAGES-1];
endmodule

// File: rtl/gpio_datapath.sv
module gpio_datapath
  import gpio_latch_pkg::*;
#(
  parameter int NUM_PINS = 12
) (
  input  logic                clk,
  input  logic                rstN,
  input  regStrobe_t          strobe,
  input  rdSel_t              rdSel,
  input  logic [DATA_W-1:0]   wdata,
  input  logic [NUM_PINS-1:0] syncIn,
  output logic [NUM_PINS-1:0] pinOut,
  output logic [NUM_PINS-1:0] pinOe,
  output logic [DATA_W-1:0]   muxOut,
  output logic [DATA_W-1:0]   rdata,
  output logic                irq
);
  localparam int PAD_W = DATA_W - NUM_PINS;

  logic [NUM_PINS-1:0] outReg, oeReg, enaReg, stsReg, polReg;
  logic [NUM_PINS-1:0] polNext, stsNext, clrMask, hitVec;
  logic [DATA_W-1:0]   muxReg, polLoView, polHiView;

  // polarity: one bit per line, scattered across two bus registers
  always_comb begin
    polNext = polReg;
    for (int i = 0; i < NUM_PINS; i++) begin
      if (i < LINES_PER_POL) begin
        if (strobe.wrPolLo) polNext[i] = wdata[POL_STRIDE*(i%LINES_PER_POL)];
      end else begin
        if (strobe.wrPolHi) polNext[i] = wdata[POL_STRIDE*(i%LINES_PER_POL)];
      end
    end
  end

  always_comb begin
    polLoView = '0;
    polHiView = '0;
    for (int i = 0; i < NUM_PINS; i++) begin
      if (i < LINES_PER_POL) polLoView[POL_STRIDE*(i%LINES_PER_POL)] = polReg[i];
      else                   polHiView[POL_STRIDE*(i%LINES_PER_POL)] = polReg[i];
    end
  end

  // level match: pol 0 -> active high, pol 1 -> active low
  assign hitVec  = syncIn ^ polReg;
  assign clrMask = strobe.wrSts ? wdata[NUM_PINS-1:0] : '0;
  assign stsNext = (stsReg & ~clrMask) | hitVec;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outReg <= '0;
      oeReg  <= '0;
      enaReg <= '0;
      stsReg <= '0;
      polReg <= '0;
      muxReg <= '0;
    end else begin
      if (strobe.wrOut) outReg <= wdata[NUM_PINS-1:0];
      if (strobe.wrOe)  oeReg  <= wdata[NUM_PINS-1:0];
      if (strobe.wrEna) enaReg <= wdata[NUM_PINS-1:0];
      if (strobe.wrMux) muxReg <= wdata;
      polReg <= polNext;
      stsReg <= stsNext;
    end
  end

  always_comb begin
    unique case (rdSel)
      SEL_OUT:   rdata = {{PAD_W{1'b0}}, outReg};
      SEL_OE:    rdata = {{PAD_W{1'b0}}, oeReg};
      SEL_IN:    rdata = {{PAD_W{1'b0}}, syncIn};
      SEL_STS:   rdata = {{PAD_W{1'b0}}, stsReg};
      SEL_POLLO: rdata = polLoView;
      SEL_ENA:   rdata = {{PAD_W{1'b0}}, enaReg};
      SEL_POLHI: rdata = polHiView;
      SEL_MUX:   rdata = muxReg;
      default:   rdata = '0;
    endcase
  end

  assign pinOut = outReg;
  assign pinOe  = oeReg;
  assign muxOut = muxReg;
  assign irq    = |(stsReg & enaReg);
endmodule

// File: rtl/gpio_latch_irq.sv
module gpio_latch_irq
  import gpio_latch_pkg::*;
#(
  parameter int NUM_PINS    = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [REG_AW-1:0]   busAddr,
  input  logic                busWrite,
  input  logic [DATA_W-1:0]   busWdata,
  output logic [DATA_W-1:0]   busRdata,
  input  logic [NUM_PINS-1:0] pinIn,
  output logic [NUM_PINS-1:0] pinOut,
  output logic [NUM_PINS-1:0] pinOe,
  output logic [DATA_W-1:0]   muxOut,
  output logic                irq
);
  regStrobe_t          strobe;
  rdSel_t              rdSel;
  logic [NUM_PINS-1:0] syncIn;

  gpio_ctrl ctrl_i (
    .busAddr (busAddr),
    .busWrite(busWrite),
    .strobe  (strobe),
    .rdSel   (rdSel)
  );

  gpio_pin_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) sync_i (
    .clk    (clk),
    .rstN   (rstN),
    .asyncIn(pinIn),
    .syncOut(syncIn)
  );

  gpio_datapath #(.NUM_PINS(NUM_PINS)) dp_i (
    .clk   (clk),
    .rstN  (rstN),
    .strobe(strobe),
    .rdSel (rdSel),
    .wdata (busWdata),
    .syncIn(syncIn),
    .pinOut(pinOut),
    .pinOe (pinOe),
    .muxOut(muxOut),
    .rdata (busRdata),
    .irq   (irq)
  );
endmodule

// File: rtl/gpio_latch_irq_chk.sv
module gpio_latch_irq_chk
  import gpio_latch_pkg::*;
#(
  parameter int NUM_PINS = 12
) (
  input logic                clk,
  input logic                rstN,
  input logic [REG_AW-1:0]   busAddr,
  input logic                busWrite,
  input logic [DATA_W-1:0]   busWdata,
  input logic [DATA_W-1:0]   busRdata,
  input logic [NUM_PINS-1:0] pinOut,
  input logic [NUM_PINS-1:0] pinOe,
  input logic [DATA_W-1:0]   muxOut,
  input logic                irq
);
  localparam logic [DATA_W-1:0] POL_HOLES = ~32'h1111_1111;

  AST_RESET_CLEAN: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (pinOe == '0 && pinOut == '0 && muxOut == '0 && !irq)); // R1

  AST_OUT_TAKES_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (busWrite && busAddr == OFF_OUT) |=> pinOut == $past(busWdata[NUM_PINS-1:0])); // R3

  AST_OE_TAKES_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (busWrite && busAddr == OFF_OE) |=> pinOe == $past(busWdata[NUM_PINS-1:0])); // R3

  AST_IN_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == OFF_IN) |-> busRdata[DATA_W-1:NUM_PINS] == '0); // R2

  AST_POL_HOLES_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == OFF_POLLO || busAddr == OFF_POLHI) |-> (busRdata & POL_HOLES) == '0); // R5

  AST_MASK_ALL_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (busWrite && busAddr == OFF_ENA && busWdata[NUM_PINS-1:0] == '0) |=> !irq); // R8

  AST_MUX_TAKES_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (busWrite && busAddr == OFF_MUX) |=> muxOut == $past(busWdata)); // R9

  AST_MUX_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !(busWrite && busAddr == OFF_MUX) |=> $stable(muxOut)); // R9
endmodule

bind gpio_latch_irq gpio_latch_irq_chk #(.NUM_PINS(NUM_PINS)) chk_i (
  .clk     (clk),
  .rstN    (rstN),
  .busAddr (busAddr),
  .busWrite(busWrite),
  .busWdata(busWdata),
  .busRdata(busRdata),
  .pinOut  (pinOut),
  .pinOe   (pinOe),
  .muxOut  (muxOut),
  .irq     (irq)
);

// File: tb/gpio_latch_irq_tb_top.sv
module gpio_latch_irq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 12;
  localparam int WATCHDOG = 20000;

  typedef struct packed {
    logic [4:0]  addr;
    logic [31:0] wdata;
    logic [31:0] expVal;
  } vec_t;

  localparam int NVEC = 9;
  localparam vec_t VECS [NVEC] = '{
    '{5'h00, 32'hFFFF_FFFF, 32'h0000_0FFF},
    '{5'h04, 32'hA5A5_A5A5, 32'h0000_05A5},
    '{5'h14, 32'h0000_F00F, 32'h0000_000F},
    '{5'h1C, 32'hDEAD_BEEF, 32'hDEAD_BEEF},
    '{5'h08, 32'hFFFF_FFFF, 32'h0000_0000},
    '{5'h10, 32'hFFFF_FFFF, 32'h1111_1111},
    '{5'h18, 32'hFFFF_FFFF, 32'h0000_1111},
    '{5'h10, 32'h0000_0002, 32'h0000_0000},
    '{5'h18, 32'h0000_0000, 32'h0000_0000}
  };

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [4:0]    busAddr = '0;
  logic          busWrite = 1'b0;
  logic [31:0]   busWdata = '0;
  logic [31:0]   busRdata;
  logic [NP-1:0] pinIn = '0;
  logic [NP-1:0] pinOut, pinOe;
  logic [31:0]   muxOut;
  logic          irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_latch_irq dut_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrite(busWrite),
    .busWdata(busWdata), .busRdata(busRdata), .pinIn(pinIn),
    .pinOut(pinOut), .pinOe(pinOe), .muxOut(muxOut), .irq(irq)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    busAddr = a; busWdata = d; busWrite = 1'b1;
    tick();
    busWrite = 1'b0; busWdata = '0;
  endtask

  task automatic rdChk(input string tag, input logic [4:0] a, input logic [31:0] exp);
    busAddr = a;
    #1;
    check(tag, busRdata, exp);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rstN = 1'b1;
    tick();

    // R1: reset state
    for (int k = 0; k < 8; k++) rdChk("R1 reg after reset", 5'(k*4), 32'h0);
    check("R1 irq", {31'h0, irq}, 32'h0);
    check("R1 pinOe", {20'h0, pinOe}, 32'h0);
    check("R1 muxOut", muxOut, 32'h0);

    // R2 R4 R5 R9 vector table: write then read back
    for (int v = 0; v < NVEC; v++) begin
      wr(VECS[v].addr, VECS[v].wdata);
      rdChk("R2/R4/R5/R9 table readback", VECS[v].addr, VECS[v].expVal);
    end
    check("R9 muxOut port", muxOut, 32'hDEAD_BEEF);

    // restore and flush pending status, R7 all-ones acknowledge
    wr(5'h14, 32'h0);
    wr(5'h00, 32'h0);
    wr(5'h04, 32'h0);
    tick();
    wr(5'h0C, 32'hFFFF_FFFF);
    rdChk("R7 ack all", 5'h0C, 32'h0);
    check("R8 irq after ack", {31'h0, irq}, 32'h0);

    // R3: pin drivers
    wr(5'h00, 32'h0000_05A3);
    check("R3 pinOut", {20'h0, pinOut}, 32'h5A3);
    wr(5'h04, 32'h0000_00F0);
    check("R3 pinOe", {20'h0, pinOe}, 32'h0F0);

    // R4 and R6: line 3 active high, masked
    pinIn[3] = 1'b1;
    tick(); tick();
    rdChk("R4 synced input", 5'h08, 32'h8);
    rdChk("R4 status not yet set", 5'h0C, 32'h0);
    tick();
    rdChk("R6 status latched while masked", 5'h0C, 32'h8);
    check("R8 masked line no irq", {31'h0, irq}, 32'h0);
    wr(5'h14, 32'h8);
    check("R8 irq on enable", {31'h0, irq}, 32'h1);
    wr(5'h0C, 32'h8);
    rdChk("R7 clear while active re-sets", 5'h0C, 32'h8);
    pinIn[3] = 1'b0;
    tick(); tick(); tick();
    rdChk("R6 status holds after source gone", 5'h0C, 32'h8);
    wr(5'h0C, 32'h0);
    rdChk("R7 write zero keeps status", 5'h0C, 32'h8);
    wr(5'h0C, 32'h8);
    rdChk("R7 clear after source gone", 5'h0C, 32'h0);
    check("R8 irq drops after clear", {31'h0, irq}, 32'h0);

    // R5: line 9 active low via bit 4 of high polarity register
    wr(5'h18, 32'h0000_0010);
    rdChk("R5 high polarity readback", 5'h18, 32'h10);
    tick();
    rdChk("R5 line 9 active low fires", 5'h0C, 32'h200);
    pinIn[9] = 1'b1;
    tick(); tick(); tick();
    wr(5'h0C, 32'h200);
    rdChk("R5 line 9 inactive when high", 5'h0C, 32'h0);

    // R5: line 0 active low via bit 0 of low polarity register
    wr(5'h10, 32'h0000_0001);
    tick();
    rdChk("R5 line 0 active low fires", 5'h0C, 32'h1);
    check("R8 other line enabled only", {31'h0, irq}, 32'h0);
    wr(5'h14, 32'h1);
    check("R8 irq line 0", {31'h0, irq}, 32'h1);
    wr(5'h14, 32'h0);
    check("R8 mask all", {31'h0, irq}, 32'h0);
    wr(5'h10, 32'h0);
    tick();
    wr(5'h0C, 32'hFFFF_FFFF);
    rdChk("R7 final ack", 5'h0C, 32'h0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule